// File: doc/BRIEF.md
# Carry-Save Array Unsigned Multiplier

This block multiplies two small unsigned operands with no clock and no state. A row of AND gates forms one partial-product row for each multiplier bit. An array of 1-bit full-adder cells then reduces the rows. Inside the array, each cell sends its carry down to the next row, one weight higher. No carry travels sideways within a row. The lowest sum bit of each row becomes one of the low product bits. A single ripple-carry row at the bottom merges the remaining sum and carry vectors into the upper product bits.

The operand width is a parameter. The intended width is 4 bits, which gives an 8-bit product. Use the block wherever a short combinational product is needed inside a clocked datapath. The surrounding registers must allow for the block's combinational delay.

Top module: `csa_mul4`

## Requirements
- R1: For every pair of 4-bit unsigned operands, p_o equals m_i × q_i as an 8-bit unsigned value.
- R2: Product bit p_o[0] equals m_i[0] AND q_i[0], with no adder stage.
- R3: If either operand is zero, the product is zero.
- R4: Each carry-save row conserves value: its sum vector plus its carry vector, with the carries counted one weight higher, equals the sum of its three input vectors.
- R5: The products 0×10=0, 5×5=25, 9×5=45, 12×13=156, 15×10=150 and 14×11=154 are exact.
- R6: The final ripple row never produces a carry out. The largest product, 15×15=225, fits in 8 bits.
- R7: Multiplying by one returns the other operand, zero-extended, in either operand position.
- R8: The output depends only on the present inputs, so applying the same operand pair again gives the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_i | input | 4 | Multiplicand, unsigned |
| q_i | input | 4 | Multiplier, unsigned |
| p_o | output | 8 | Product, unsigned |

## Verification
A carry sent to the wrong weight, or a cell that drops an input, shows up as a wrong product for the operand pairs that use that cell. Because the block is combinational, the error appears as soon as the inputs settle. Running every operand pair therefore covers every cell with both carry polarities, so any wiring fault in the array shows as a product mismatch at the ports. The row-conservation checks inside the array point to the faulty row, even where the final ripple row would otherwise hide which stage went wrong.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
  typedef struct packed {
    logic carry;
    logic sum;
  } fa_res_t;

  function automatic fa_res_t fa_eval(input logic a, input logic b, input logic c);
    fa_res_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (a & c) | (b & c);
    return r;
  endfunction
endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell
  import csa_mul_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  fa_res_t res;
  always_comb res = fa_eval(a_i, b_i, c_i);
  assign s_o  = res.sum;
  assign co_o = res.carry;
endmodule

// File: rtl/csa_pp_row.sv
module csa_pp_row #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] m_i,
  input  logic         q_bit_i,
  output logic [N-1:0] pp_o
);
  assign pp_o = m_i & {N{q_bit_i}};
endmodule

// File: rtl/csa_add_row.sv
// One carry-save row: N independent full adders, carries go to the next row.
module csa_add_row #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] s_o,
  output logic [N-1:0] c_o
);
  localparam int unsigned W = N + 2;

  for (genvar i = 0; i < N; i++) begin : g_cell
    csa_fa_cell u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (c_i[i]),
      .s_o (s_o[i]),
      .co_o(c_o[i])
    );
  end

  always_comb begin
    assert_row_conserve_R4: assert (W'(s_o) + (W'(c_o) << 1) == W'(a_i) + W'(b_i) + W'(c_i))
      else $error("R4 carry-save row lost value");
  end
endmodule

// File: rtl/csa_ripple_row.sv
module csa_ripple_row #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] s_o,
  output logic         co_o
);
  logic [N:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    csa_fa_cell u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (cy[i]),
      .s_o (s_o[i]),
      .co_o(cy[i+1])
    );
  end

  assign co_o = cy[N];
endmodule

// File: rtl/csa_mul4.sv
module csa_mul4 #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   m_i,
  input  logic [N-1:0]   q_i,
  output logic [2*N-1:0] p_o
);
  localparam int unsigned PW = 2 * N;

  logic [N-1:0] pp    [N];
  logic [N-1:0] row_a [N];
  logic [N-1:0] row_c [N];
  logic [N-1:0] row_s [N];
  logic [N-1:0] row_co[N];
  logic [N-1:0] hi_sum;
  logic         hi_co;

  for (genvar j = 0; j < N; j++) begin : g_pp
    csa_pp_row #(.N(N)) u_pp (
      .m_i    (m_i),
      .q_bit_i(q_i[j]),
      .pp_o   (pp[j])
    );
  end

  assign p_o[0]   = pp[0][0];
  assign row_a[0] = {1'b0, pp[0][N-1:1]};
  assign row_c[0] = '0;
  assign row_s[0] = '0;
  assign row_co[0] = '0;

  // Row j sums weights j..j+N-1; carries go one weight up into row j+1.
  for (genvar j = 1; j < N; j++) begin : g_row
    if (j > 1) begin : g_link
      assign row_a[j] = {1'b0, row_s[j-1][N-1:1]};
      assign row_c[j] = row_co[j-1];
    end else begin : g_first
      assign row_a[j] = row_a[0];
      assign row_c[j] = row_c[0];
    end
    csa_add_row #(.N(N)) u_row (
      .a_i(row_a[j]),
      .b_i(pp[j]),
      .c_i(row_c[j]),
      .s_o(row_s[j]),
      .c_o(row_co[j])
    );
    assign p_o[j] = row_s[j][0];
  end

  csa_ripple_row #(.N(N)) u_cpa (
    .a_i ({1'b0, row_s[N-1][N-1:1]}),
    .b_i (row_co[N-1]),
    .s_o (hi_sum),
    .co_o(hi_co)
  );
  assign p_o[PW-1:N] = hi_sum;

  always_comb begin
    assert_final_no_carry_R6: assert (hi_co == 1'b0)
      else $error("R6 final row carried out");
    assert_product_exact_R1: assert (p_o == PW'(m_i) * PW'(q_i))
      else $error("R1 product mismatch");
    assert_low_bit_R2: assert (p_o[0] == (m_i[0] & q_i[0]))
      else $error("R2 low bit mismatch");
    assert_zero_operand_R3: assert (!((m_i == '0) || (q_i == '0)) || (p_o == '0))
      else $error("R3 zero operand gave nonzero product");
  end
endmodule

// File: tb/csa_mul4_test.sv
module csa_mul4_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [3:0] m_i, q_i;
  logic [7:0] p_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_mul4 uut (.m_i(m_i), .q_i(q_i), .p_o(p_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s m=%0d q=%0d actual=%0d expected=%0d", req, m_i, q_i, act, exp);
    end
  endtask

  // Drive at posedge, sample at negedge.
  task automatic apply(input int a, input int b);
    @(posedge clk);
    m_i = 4'(a);
    q_i = 4'(b);
    @(negedge clk);
  endtask

  initial begin
    int ref_q[$];
    m_i = '0;
    q_i = '0;
    apply(0, 0);
    chk("R3 reset-state zero", p_o, 0);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        ref_q.push_back(a * b);
        apply(a, b);
        chk("R1 R4 exhaustive", p_o, ref_q.pop_front());
        chk("R2 low bit", p_o[0], (a & b) & 1);
      end

    apply(0, 10);  chk("R5 0x10", p_o, 0);
    apply(5, 5);   chk("R5 5x5", p_o, 25);
    apply(9, 5);   chk("R5 9x5", p_o, 45);
    apply(12, 13); chk("R5 12x13", p_o, 156);
    apply(15, 10); chk("R5 15x10", p_o, 150);
    apply(14, 11); chk("R5 14x11", p_o, 154);
    apply(15, 15); chk("R6 max product", p_o, 225);
    apply(15, 0);  chk("R3 zero multiplier", p_o, 0);
    apply(0, 15);  chk("R3 zero multiplicand", p_o, 0);
    apply(13, 1);  chk("R7 times one right", p_o, 13);
    apply(1, 11);  chk("R7 times one left", p_o, 11);
    apply(7, 9);   chk("R8 first apply", p_o, 63);
    apply(3, 2);   chk("R8 other pair", p_o, 6);
    apply(7, 9);   chk("R8 repeat apply", p_o, 63);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule